// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block turns a stream of 32-bit words fetched from a framebuffer into a stream of single pixels. The pixel depth, the order in which pixels are packed inside a word and the red/blue channel order are chosen by static configuration inputs. Depths of 8 bits or fewer produce palette indices, which a later palette stage resolves. Depths of 12, 16 and 32 bits produce a direct 24-bit colour. A variant strap selects between the basic and the extended format set. On the basic variant, a 2-bit board-level selector decides how a 16-bit pixel is read.

Words enter on a valid/ready handshake and pixels leave on a second valid/ready handshake. Each output pixel carries a flag that tells a palette index from a direct colour, and an end-of-line flag that marks the last pixel of a line. The block also reports, combinationally, how many bytes one line of the configured width occupies. Configuration inputs and the line width may only change while the block is idle, which means no word is held and the previous line is complete.

Top module: `pxu_unpacker`

## Requirements
- R1: Depth codes map to container sizes as follows: 0 is 1 bit, 1 is 2 bits, 2 is 4 bits, 3 is 8 bits, 4 is 16 bits, 5 is 32 bits, 6 is 16 bits and 7 is 16 bits. A word therefore holds 32, 16, 8, 4, 2 or 1 pixels. Codes 0 to 3 output the container value, zero-extended to 24 bits, with `out_is_index` high.
- R2: `line_bytes` is `line_width` shifted right by 3, 2 or 1 for 1, 2 and 4 bits, equal to `line_width` for 8 bits, `line_width`*2 for every 16-bit and 12-bit format, and `line_width`*4 for 32 bits. The result is rounded down.
- R3: On the basic variant (`ext_variant`=0), codes 4, 6 and 7 behave the same way and depend on `sel16`. Value 1 gives 1555. Value 3 gives 565 with red and blue always swapped, whatever `bgr` is. Values 0 and 2 give 565 with `bgr` honoured.
- R4: On the extended variant, `sel16` has no effect. Code 4 is 1555, code 6 is 565 and code 7 is 444, which uses the low 12 bits of the 16-bit container.
- R5: Output bits [7:0] are red, [15:8] are green and [23:16] are blue. The container fields, from the LSB up, are red then green then blue: 5/5/5 for 1555 (bit 15 is ignored), 5/6/5 for 565, 4/4/4 for 444 and 8/8/8 for 32 bits (the top byte is ignored). Narrow channels are left-shifted and zero-filled to 8 bits.
- R6: When `bgr`=1, the red and blue output channels of direct colours are swapped. `bgr` has no effect on index output.
- R7: With `b` bits per container and `P` pixels per word, pixel k of a word is read from bits [s*b +: b]. With both order bits clear, s = k. With `be_bytes`=1, s = P-1-k, so the first pixel comes from the most significant container, and this holds whatever `be_pixels` is. With only `be_pixels`=1 and b<8, the bytes are taken LSB byte first, and inside each byte the most significant container comes first. For b>=8, `be_pixels` alone has no effect.
- R8: `out_eol` is high on pixel number `line_width` of each line, counting from 1. Any pixels left in that word are discarded, and the next line starts with the next word.
- R9: While `out_valid`=1 and `out_ready`=0, the output pixel and its flags hold steady. A new word is accepted in the same cycle as the last pixel of the held word leaves, so with both sides always ready one pixel leaves every cycle.
- R10: After synchronous reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| depth_code | input | 3 | Pixel depth code |
| be_bytes | input | 1 | Big-endian byte order, whole word most significant first |
| be_pixels | input | 1 | Big-endian pixel order within bytes |
| bgr | input | 1 | Swap red and blue output channels |
| ext_variant | input | 1 | Extended format set strap |
| sel16 | input | 2 | 16-bit format selector, basic variant only |
| line_width | input | WIDTH_W | Pixels per line, at least 1 |
| line_bytes | output | WIDTH_W+2 | Bytes occupied by one line |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word accepted when valid |
| in_data | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Pixel consumer ready |
| out_pix | output | 24 | Palette index or colour, red in [7:0] |
| out_is_index | output | 1 | Pixel is a palette index |
| out_eol | output | 1 | Last pixel of a line |

## Verification
Two events can land on the same clock edge: the end of a line, which drops the unused rest of the held word, and the refill of the word register from the input. A third combination is the last pixel of a word leaving while a stall ends on the same edge. The bench provokes these with line widths that are not multiples of the pixels per word, under both saturated and random ready/valid patterns. It judges every pixel, including its flags, against a reference stream built from the requirements. In saturated runs it also checks that no cycle between the first and last pixel is idle.

// File: rtl/pxu_pkg.sv
// Package: shared format descriptor and channel widening helpers for the
// pixel unpacker. Assumes 32-bit framebuffer words.
package pxu_pkg;

    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;

    // Pixel interpretation chosen from depth code, variant and selector.
    typedef enum logic [2:0] {
        FMT_INDEX    = 3'd0,
        FMT_ARGB1555 = 3'd1,
        FMT_RGB565   = 3'd2,
        FMT_RGB444   = 3'd3,
        FMT_RGB888   = 3'd4
    } fmt_kind_e;

    typedef struct packed {
        fmt_kind_e  kind;
        logic [2:0] lbits;    // log2 of container width in bits
        logic       swap_rb;  // exchange red and blue on output
    } fmt_t;

    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, 3'b000};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, 2'b00};
    endfunction

    function automatic logic [7:0] widen4(input logic [3:0] v);
        return {v, 4'b0000};
    endfunction

endpackage

// File: rtl/pxu_fmt_resolve.sv
// Module: pxu_fmt_resolve
// Maps depth code, variant strap, 16-bit selector and BGR bit to a format
// descriptor. Purely combinational; inputs are assumed static while streaming.
module pxu_fmt_resolve
    import pxu_pkg::*;
(
    input  logic [2:0] depth_code,
    input  logic       ext_variant,
    input  logic [1:0] sel16,
    input  logic       bgr,
    output fmt_t       fmt
);

    // Decode the descriptor for the current configuration.
    always_comb begin
        fmt.kind    = FMT_INDEX;
        fmt.lbits   = 3'd0;
        fmt.swap_rb = 1'b0;
        case (depth_code)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                fmt.lbits = depth_code;
            end
            3'd5: begin
                fmt.kind    = FMT_RGB888;
                fmt.lbits   = 3'd5;
                fmt.swap_rb = bgr;
            end
            default: begin
                fmt.lbits = 3'd4;
                if (!ext_variant) begin
                    case (sel16)
                        2'd1: begin
                            fmt.kind    = FMT_ARGB1555;
                            fmt.swap_rb = bgr;
                        end
                        2'd3: begin
                            fmt.kind    = FMT_RGB565;
                            fmt.swap_rb = 1'b1;
                        end
                        default: begin
                            fmt.kind    = FMT_RGB565;
                            fmt.swap_rb = bgr;
                        end
                    endcase
                end else begin
                    fmt.swap_rb = bgr;
                    case (depth_code)
                        3'd4:    fmt.kind = FMT_ARGB1555;
                        3'd6:    fmt.kind = FMT_RGB565;
                        default: fmt.kind = FMT_RGB444;
                    endcase
                end
            end
        endcase
    end

endmodule

// File: rtl/pxu_line_bytes.sv
// Module: pxu_line_bytes
// Computes the byte length of one line from the pixel count and the
// container width. Sub-byte depths round down.
module pxu_line_bytes #(
    parameter int WIDTH_W = 12
) (
    input  logic [WIDTH_W-1:0] line_width,
    input  logic [2:0]         lbits,
    output logic [WIDTH_W+1:0] line_bytes
);

    localparam int OUT_W = WIDTH_W + 2;

    logic [OUT_W-1:0] wide;

    // Scale the width by container bits over eight.
    always_comb begin
        wide = {2'b00, line_width};
        if (lbits >= 3'd3)
            line_bytes = wide << (lbits - 3'd3);
        else
            line_bytes = wide >> (3'd3 - lbits);
    end

endmodule

// File: rtl/pxu_slot_pick.sv
// Module: pxu_slot_pick
// Selects the container of pixel number pix_idx from a word, applying the
// byte-order and pixel-order options. Assumes pix_idx below the pixels per word.
module pxu_slot_pick
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [4:0]        pix_idx,
    input  logic [2:0]        lbits,
    input  logic              be_bytes,
    input  logic              be_pixels,
    output logic [WORD_W-1:0] raw
);

    logic [5:0]        per_word;
    logic [3:0]        per_byte;
    logic [4:0]        word_flip;
    logic [4:0]        byte_flip;
    logic [4:0]        slot;
    logic [4:0]        shamt;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] cand [8];

    // Turn the pixel index into a container slot via index reflection.
    always_comb begin
        per_word  = 6'd32 >> lbits;
        per_byte  = 4'd8 >> lbits;
        word_flip = 5'(per_word - 6'd1);
        byte_flip = (lbits < 3'd3) ? {2'b00, 3'(per_byte - 4'd1)} : 5'd0;
        if (be_bytes)
            slot = pix_idx ^ word_flip;
        else if (be_pixels)
            slot = pix_idx ^ byte_flip;
        else
            slot = pix_idx;
        shamt   = 5'(slot << lbits);
        shifted = word >> shamt;
    end

    // One masked candidate per container width.
    for (genvar g = 0; g < 8; g++) begin : g_mask
        if (g == 5) begin : g_full
            assign cand[g] = shifted;
        end else if (g < 5) begin : g_part
            localparam int CW = 1 << g;
            assign cand[g] = {{(WORD_W-CW){1'b0}}, shifted[CW-1:0]};
        end else begin : g_none
            assign cand[g] = '0;
        end
    end

    // Pick the candidate for the active width.
    always_comb raw = cand[lbits];

endmodule

// File: rtl/pxu_color_map.sv
// Module: pxu_color_map
// Interprets a raw container as index or colour and packs it with red in
// the low byte, applying the red/blue swap for direct colours.
module pxu_color_map
    import pxu_pkg::*;
(
    input  fmt_t              fmt,
    input  logic [WORD_W-1:0] raw,
    output logic [PIX_W-1:0]  pix,
    output logic              is_index
);

    logic [7:0] red, grn, blu;

    // Split fields and widen each channel to eight bits.
    always_comb begin
        red      = 8'h00;
        grn      = 8'h00;
        blu      = 8'h00;
        is_index = 1'b0;
        case (fmt.kind)
            FMT_ARGB1555: begin
                red = widen5(raw[4:0]);
                grn = widen5(raw[9:5]);
                blu = widen5(raw[14:10]);
            end
            FMT_RGB565: begin
                red = widen5(raw[4:0]);
                grn = widen6(raw[10:5]);
                blu = widen5(raw[15:11]);
            end
            FMT_RGB444: begin
                red = widen4(raw[3:0]);
                grn = widen4(raw[7:4]);
                blu = widen4(raw[11:8]);
            end
            FMT_RGB888: begin
                red = raw[7:0];
                grn = raw[15:8];
                blu = raw[23:16];
            end
            default: is_index = 1'b1;
        endcase
    end

    // Pack the output word.
    always_comb begin
        if (is_index)
            pix = {16'h0000, raw[7:0]};
        else if (fmt.swap_rb)
            pix = {red, grn, blu};
        else
            pix = {blu, grn, red};
    end

endmodule

// File: rtl/pxu_unpacker.sv
// Module: pxu_unpacker (top)
// Holds one framebuffer word and emits its pixels one per accepted output
// cycle, ending words early at line end. Refills in the same cycle the last
// pixel leaves. Configuration and line_width must only change while idle.
module pxu_unpacker
    import pxu_pkg::*;
#(
    parameter int WIDTH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         depth_code,
    input  logic               be_bytes,
    input  logic               be_pixels,
    input  logic               bgr,
    input  logic               ext_variant,
    input  logic [1:0]         sel16,
    input  logic [WIDTH_W-1:0] line_width,
    output logic [WIDTH_W+1:0] line_bytes,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [23:0]        out_pix,
    output logic               out_is_index,
    output logic               out_eol
);

    fmt_t               fmt;
    logic [WORD_W-1:0]  word_q;
    logic               held_q;
    logic [4:0]         widx_q;
    logic [WIDTH_W-1:0] lidx_q;
    logic [WORD_W-1:0]  raw;
    logic [5:0]         per_word;
    logic               fire;
    logic               line_end;
    logic               word_end;
    logic               drop_word;

    pxu_fmt_resolve u_fmt (
        .depth_code  (depth_code),
        .ext_variant (ext_variant),
        .sel16       (sel16),
        .bgr         (bgr),
        .fmt         (fmt)
    );

    pxu_line_bytes #(.WIDTH_W(WIDTH_W)) u_bytes (
        .line_width (line_width),
        .lbits      (fmt.lbits),
        .line_bytes (line_bytes)
    );

    pxu_slot_pick u_pick (
        .word      (word_q),
        .pix_idx   (widx_q),
        .lbits     (fmt.lbits),
        .be_bytes  (be_bytes),
        .be_pixels (be_pixels),
        .raw       (raw)
    );

    pxu_color_map u_map (
        .fmt      (fmt),
        .raw      (raw),
        .pix      (out_pix),
        .is_index (out_is_index)
    );

    // Handshake and position decode for the held word.
    always_comb begin
        per_word  = 6'd32 >> fmt.lbits;
        fire      = held_q && out_ready;
        line_end  = (lidx_q == WIDTH_W'(line_width - 1'b1));
        word_end  = ({1'b0, widx_q} == (per_word - 6'd1));
        drop_word = fire && (line_end || word_end);
        in_ready  = !held_q || drop_word;
        out_valid = held_q;
        out_eol   = line_end;
    end

    // Word register, pixel-in-word and pixel-in-line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            held_q <= 1'b0;
            widx_q <= '0;
            lidx_q <= '0;
        end else begin
            if (fire) begin
                widx_q <= drop_word ? 5'd0 : widx_q + 5'd1;
                lidx_q <= line_end ? '0 : lidx_q + 1'b1;
            end
            if (in_valid && in_ready) begin
                word_q <= in_data;
                held_q <= 1'b1;
            end else if (drop_word) begin
                held_q <= 1'b0;
            end
        end
    end

    // Independent count of pixels since the last line end, for checking.
    logic [WIDTH_W-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_cnt <= '0;
        else if (fire)
            chk_cnt <= out_eol ? '0 : chk_cnt + 1'b1;
    end

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) &&
                                       $stable(out_eol) && $stable(out_is_index)));

    assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_eol_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_eol) |-> (chk_cnt == WIDTH_W'(line_width - 1'b1)));

    assert_index_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_index) |-> (out_pix[23:8] == 16'h0000));

    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_index && fmt.kind != FMT_RGB888)
            |-> (out_pix[2:0] == 3'b000 && out_pix[18:16] == 3'b000));

endmodule

// File: tb/sim_pxu_unpacker.sv
module sim_pxu_unpacker;

    localparam int WW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    depth_code = 3'd0;
    logic          be_bytes = 1'b0;
    logic          be_pixels = 1'b0;
    logic          bgr = 1'b0;
    logic          ext_variant = 1'b0;
    logic [1:0]    sel16 = 2'd0;
    logic [WW-1:0] line_width = 12'd1;
    logic [WW+1:0] line_bytes;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_data = 32'h0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [23:0]   out_pix;
    logic          out_is_index;
    logic          out_eol;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pxu_unpacker #(.WIDTH_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .depth_code(depth_code), .be_bytes(be_bytes),
        .be_pixels(be_pixels), .bgr(bgr), .ext_variant(ext_variant), .sel16(sel16),
        .line_width(line_width), .line_bytes(line_bytes), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix), .out_is_index(out_is_index),
        .out_eol(out_eol)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ref_lbits();
        case (depth_code)
            3'd0: return 0;
            3'd1: return 1;
            3'd2: return 2;
            3'd3: return 3;
            3'd5: return 5;
            default: return 4;
        endcase
    endfunction

    // Expected {is_index, pix} for pixel k of word w under the current config.
    function automatic logic [24:0] ref_pix(input logic [31:0] w, input int k);
        int lb, b, ppw, ppb, s, d;
        logic [31:0] v;
        logic [7:0] r, g, bl;
        bit sw;
        lb = ref_lbits(); b = 1 << lb; ppw = 32 / b; ppb = (b < 8) ? 8 / b : 1;
        s = k;
        if (be_bytes) s = ppw - 1 - k;
        else if (be_pixels && b < 8) s = (k / ppb) * ppb + (ppb - 1 - (k % ppb));
        v = w >> (s * b);
        if (b < 32) v = v & ((32'd1 << b) - 32'd1);
        d = depth_code;
        if (d <= 3) return {1'b1, 16'h0, v[7:0]};
        sw = bgr; r = 0; g = 0; bl = 0;
        if (d == 5) begin
            r = v[7:0]; g = v[15:8]; bl = v[23:16];
        end else begin
            int kind; // 1=1555 2=565 3=444
            if (!ext_variant) begin
                if (sel16 == 2'd1) kind = 1;
                else begin kind = 2; if (sel16 == 2'd3) sw = 1'b1; end
            end else kind = (d == 4) ? 1 : (d == 6) ? 2 : 3;
            if (kind == 1) begin
                r = {v[4:0], 3'b0}; g = {v[9:5], 3'b0}; bl = {v[14:10], 3'b0};
            end else if (kind == 2) begin
                r = {v[4:0], 3'b0}; g = {v[10:5], 2'b0}; bl = {v[15:11], 3'b0};
            end else begin
                r = {v[3:0], 4'b0}; g = {v[7:4], 4'b0}; bl = {v[11:8], 4'b0};
            end
        end
        return {1'b0, sw ? {r, g, bl} : {bl, g, r}};
    endfunction

    task automatic set_cfg(input int d, input bit e, input int s, input bit g,
                           input bit bb, input bit bp, input int w);
        @(negedge clk);
        depth_code = 3'(d); ext_variant = e; sel16 = 2'(s); bgr = g;
        be_bytes = bb; be_pixels = bp; line_width = WW'(w);
    endtask

    // Stream `lines` lines through the block and compare every pixel.
    task automatic run_stream(input int lines, input bit full, input string req);
        logic [31:0] words[$];
        logic [25:0] expq[$];
        int lb, ppw, wpl, width, wi, ei, cyc, first_c, last_c;
        bit acc, stalled;
        logic [25:0] held_v;
        width = int'(line_width);
        lb = ref_lbits(); ppw = 32 >> lb; wpl = (width + ppw - 1) / ppw;
        for (int ln = 0; ln < lines; ln++)
            for (int wd = 0; wd < wpl; wd++) begin
                logic [31:0] w;
                w = $urandom;
                words.push_back(w);
                for (int k = 0; k < ppw; k++) begin
                    int idx;
                    idx = wd * ppw + k;
                    if (idx < width) expq.push_back({(idx == width - 1), ref_pix(w, k)});
                end
            end
        wi = 0; ei = 0; cyc = 0; first_c = -1; last_c = 0; acc = 0; stalled = 0;
        held_v = '0;
        while (ei < expq.size()) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                check(0, req, "stream stuck", 32'(ei), 32'(expq.size()));
                break;
            end
            if (stalled)
                check(out_valid && {out_eol, out_is_index, out_pix} == held_v,
                      "R9", "stalled pixel moved", {6'h0, out_eol, out_is_index, out_pix},
                      {6'h0, held_v});
            out_ready = full ? 1'b1 : ($urandom % 4 != 0);
            if (!in_valid || acc) begin
                acc = 0;
                if (wi < words.size()) begin
                    in_valid = full ? 1'b1 : ($urandom % 3 != 0);
                    in_data = words[wi];
                end else in_valid = 1'b0;
            end
            #1;
            if (out_valid && out_ready) begin
                check({out_eol, out_is_index, out_pix} == expq[ei], req, "pixel",
                      {6'h0, out_eol, out_is_index, out_pix}, {6'h0, expq[ei]});
                if (first_c < 0) first_c = cyc;
                last_c = cyc;
                ei++;
            end
            stalled = out_valid && !out_ready;
            held_v = {out_eol, out_is_index, out_pix};
            if (in_valid && in_ready) begin wi++; acc = 1; end
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        if (full)
            check(last_c - first_c == expq.size() - 1, "R9", "gap-free stream",
                  32'(last_c - first_c), 32'(expq.size() - 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
        @(negedge clk); rst_n = 1'b1; #1;
        check(out_valid == 1'b0, "R10", "out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", 32'(in_ready), 32'd1);

        // R2: line byte count for every code on both variants.
        for (int e = 0; e < 2; e++)
            for (int d = 0; d < 8; d++) begin
                int w, exp_b;
                w = 1 + ($urandom % 4095);
                set_cfg(d, e[0], 0, 0, 0, 0, w);
                #1;
                case (ref_lbits())
                    0: exp_b = w / 8;
                    1: exp_b = w / 4;
                    2: exp_b = w / 2;
                    3: exp_b = w;
                    4: exp_b = w * 2;
                    default: exp_b = w * 4;
                endcase
                check(int'(line_bytes) == exp_b, "R2", "line bytes", 32'(line_bytes), 32'(exp_b));
            end

        // R1 R8: index depths, widths off the word boundary.
        set_cfg(3, 0, 0, 0, 0, 0, 7);  run_stream(3, 1, "R1/R8 8bit");
        set_cfg(0, 0, 0, 0, 0, 0, 5);  run_stream(3, 0, "R1/R8 1bit");
        set_cfg(1, 1, 2, 1, 0, 0, 17); run_stream(2, 1, "R1/R6 2bit bgr ignored");
        // R7: ordering options.
        set_cfg(0, 0, 0, 0, 0, 1, 20); run_stream(2, 1, "R7 pixel order 1bit");
        set_cfg(0, 0, 0, 0, 1, 1, 33); run_stream(2, 0, "R7 byte order priority");
        set_cfg(2, 0, 0, 0, 0, 1, 9);  run_stream(2, 1, "R7 pixel order 4bit");
        set_cfg(1, 0, 0, 0, 1, 0, 6);  run_stream(2, 1, "R7 byte order 2bit");
        set_cfg(4, 1, 0, 0, 0, 1, 4);  run_stream(2, 1, "R7 pixel order no effect 16bit");
        set_cfg(4, 0, 1, 0, 1, 0, 3);  run_stream(2, 0, "R7 byte order 16bit");
        // R3: basic variant selector on 16-bit codes.
        for (int s = 0; s < 4; s++)
            for (int g = 0; g < 2; g++) begin
                set_cfg(4, 0, s, g[0], 0, 0, 5); run_stream(2, 1, "R3/R5/R6 sel16");
            end
        set_cfg(6, 0, 3, 0, 0, 0, 3); run_stream(2, 1, "R3 code 6 basic");
        set_cfg(7, 0, 1, 1, 0, 0, 3); run_stream(2, 1, "R3 code 7 basic");
        // R4: extended variant ignores selector.
        for (int d = 4; d < 8; d++) begin
            if (d == 5) continue;
            for (int s = 0; s < 4; s += 3) begin
                set_cfg(d, 1, s, 0, 0, 0, 6); run_stream(2, 1, "R4/R5 extended");
                set_cfg(d, 1, s, 1, 0, 0, 6); run_stream(1, 0, "R4/R6 extended bgr");
            end
        end
        // R5 R6: 32-bit, width of one.
        set_cfg(5, 0, 0, 1, 1, 0, 1); run_stream(4, 1, "R5/R6/R8 32bit width1");
        set_cfg(5, 1, 0, 0, 0, 0, 3); run_stream(2, 0, "R5 32bit");

        // Random configurations.
        for (int t = 0; t < 24; t++) begin
            set_cfg($urandom % 8, 1'($urandom), $urandom % 4, 1'($urandom),
                    1'($urandom), 1'($urandom), 1 + ($urandom % 40));
            run_stream(3, 1'($urandom % 2), "R1/R3/R4/R5/R6/R7/R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule